// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Generator

This block turns a single fast core clock into four derived clocks: a full-rate clock, a CPU clock whose rate is picked at run time by a two-bit code, a medium-rate clock and a slow clock. The CPU rate can be lowered to save power and raised again while everything keeps running. A change of rate never produces a short high or low phase on the CPU clock. Each derived clock leaves the block twice: once free-running, and once gated by a per-output enable that can only stop or start the clock on whole phases.

In this model every derived clock is a register that toggles on core-clock edges. A clock with half-period N stays at each level for N core cycles. The core clock is normally the reference input. For test, a select input can swap in an external clock instead. A two-bit monitor output reports the rate code that is currently in force.

Output index map: 0 = full rate, 1 = CPU clock, 2 = medium clock, 3 = slow clock.

Top module: `clkgen_top`

## Requirements
- R1: While `rst_n` is low, every free and gated output is 0 and `rate_mon` is 0.
- R2: Once reset is released, output 0 changes level on every core-clock edge.
- R3: Output 1 has a half-period of 1, 2, 4 or 8 core cycles when the active code is 0, 1, 2 or 3.
- R4: Output 2 has a half-period of `HALF_MID` core cycles and output 3 a half-period of `HALF_SLOW` core cycles.
- R5: `rate_sel` is registered once. A differing registered code is adopted only at the end of a complete low phase of the old CPU clock. The output then stays low for a full half-period of the new rate. Every high phase lasts exactly the active half-period, and every low phase lasts at least that long.
- R6: `rate_mon` shows the active code. It changes only at the switch point described in R5.
- R7: `gate_en` is registered once. A gated output is never high while its free output is low. It follows its free output while the registered enable stays high, and it remains low while the enable stays low.
- R8: The registered enable is taken only while the free clock is low. A gated high phase therefore always has the full length of its free high phase.
- R9: After reset the CPU code is 0 (divide-by-1), and all gated outputs are enabled until the first registered enable value replaces the reset value.
- R10: With `use_ext` high, the core clock is `clk_ext`. All outputs hold while `clk_ext` is idle, and output 0 toggles once per `clk_ext` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| clk_ext | input | 1 | External test clock |
| use_ext | input | 1 | 1 selects clk_ext as the core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | CPU rate code, half-period = 2^code |
| gate_en | input | 4 | Per-output enable of the gated clocks |
| clk_free | output | 4 | Free-running derived clocks |
| clk_gated | output | 4 | Gated derived clocks |
| rate_mon | output | 2 | Currently active CPU rate code |

## Verification
A free output changes level one core edge after its phase counter reaches its last count. A new rate code is registered one edge after it is driven, and it is adopted only at the next low-phase end. A gate enable is registered one edge after it is driven, and it reaches the gated output at the next rising edge of the free clock. The bench keeps a behavioural model that applies these same delays on each rising reference edge, and it compares every output at the following falling edge. Separate run-length counters measure each high and low phase of the CPU clock and its gated copy, and compare them against the monitored rate. This confirms that no phase is shortened around a rate switch or a change of enable.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NUM_OUT   = 4;
  localparam int OUT_FAST  = 0;
  localparam int OUT_CPU   = 1;
  localparam int OUT_MID   = 2;
  localparam int OUT_SLOW  = 3;
  localparam int RATE_W    = 2;

  // counter width needed to count 0 .. half-1
  function automatic int cnt_width(input int half);
    return (half > 1) ? $clog2(half) : 1;
  endfunction

  // half-period in core cycles of the CPU clock for a rate code
  function automatic int unsigned rate_half(input logic [RATE_W-1:0] code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/clkgen_fixed_div.sv
module clkgen_fixed_div #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic level,
  output logic tick
);
  localparam int CW = clkgen_pkg::cnt_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      level <= ~level;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkgen_rate_div.sv
module clkgen_rate_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_in,
  output logic             level,
  output logic             tick,
  output logic [SEL_W-1:0] active,
  output logic             switch_evt
);
  localparam int CW = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_req;
  logic [CW-1:0]    cnt;
  logic [CW:0]      half;
  logic             phase_end;

  assign half       = {{CW{1'b0}}, 1'b1} << active;
  assign phase_end  = ({1'b0, cnt} == (half - 1'b1));
  assign switch_evt = phase_end && !level && (sel_req != active);
  assign tick       = phase_end && !switch_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_req <= '0;
      active  <= '0;
      cnt     <= '0;
      level   <= 1'b0;
    end else begin
      sel_req <= sel_in;
      if (switch_evt) begin
        active <= sel_req;
        cnt    <= '0;
      end else if (phase_end) begin
        level  <= ~level;
        cnt    <= '0;
      end else begin
        cnt    <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic free_level,
  input  logic free_tick,
  output logic gated
);
  logic en_q;
  logic en_hold;
  logic en_use;
  logic free_next;

  assign free_next = free_level ^ free_tick;
  assign en_use    = free_level ? en_hold : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b1;
      en_hold <= 1'b1;
      gated   <= 1'b0;
    end else begin
      en_q  <= en_in;
      if (!free_level) en_hold <= en_q;
      gated <= free_next & en_use;
    end
  end
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top #(
  parameter int HALF_FAST = 1,
  parameter int HALF_MID  = 33,
  parameter int HALF_SLOW = 330
) (
  input  logic       clk_ref,
  input  logic       clk_ext,
  input  logic       use_ext,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic [3:0] gate_en,
  output logic [3:0] clk_free,
  output logic [3:0] clk_gated,
  output logic [1:0] rate_mon
);
  import clkgen_pkg::*;

  logic               core_clk;
  logic [NUM_OUT-1:0] lvl;
  logic [NUM_OUT-1:0] tck;
  logic               cpu_switch;

  assign core_clk = use_ext ? clk_ext : clk_ref;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    if (i == OUT_CPU) begin : g_rate
      clkgen_rate_div #(.SEL_W(RATE_W)) u_div (
        .clk        (core_clk),
        .rst_n      (rst_n),
        .sel_in     (rate_sel),
        .level      (lvl[i]),
        .tick       (tck[i]),
        .active     (rate_mon),
        .switch_evt (cpu_switch)
      );
    end else begin : g_fixed
      localparam int H = (i == OUT_FAST) ? HALF_FAST :
                         (i == OUT_MID)  ? HALF_MID  : HALF_SLOW;
      clkgen_fixed_div #(.HALF(H)) u_div (
        .clk   (core_clk),
        .rst_n (rst_n),
        .level (lvl[i]),
        .tick  (tck[i])
      );
    end

    clkgen_gate u_gate (
      .clk        (core_clk),
      .rst_n      (rst_n),
      .en_in      (gate_en[i]),
      .free_level (lvl[i]),
      .free_tick  (tck[i]),
      .gated      (clk_gated[i])
    );
  end

  assign clk_free = lvl;
endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker (
  input logic       core_clk,
  input logic       rst_n,
  input logic [3:0] clk_free,
  input logic [3:0] clk_gated,
  input logic [1:0] rate_mon,
  input logic       cpu_switch
);
  logic started;

  always_ff @(posedge core_clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_FAST_TOGGLE: assert property (@(posedge core_clk) disable iff (!rst_n)
    started |-> (clk_free[0] != $past(clk_free[0]))); // R2

  AST_SWITCH_IN_LOW: assert property (@(posedge core_clk) disable iff (!rst_n)
    cpu_switch |-> !clk_free[1]); // R5

  AST_SWITCH_HOLDS_LOW: assert property (@(posedge core_clk) disable iff (!rst_n)
    cpu_switch |=> !clk_free[1]); // R5

  AST_MON_ONLY_AT_SWITCH: assert property (@(posedge core_clk) disable iff (!rst_n)
    (started && !cpu_switch) |=> $stable(rate_mon)); // R6

  for (genvar i = 0; i < 4; i++) begin : g_chk
    AST_GATED_UNDER_FREE: assert property (@(posedge core_clk) disable iff (!rst_n)
      clk_gated[i] |-> clk_free[i]); // R7

    AST_GATED_FULL_HIGH: assert property (@(posedge core_clk) disable iff (!rst_n)
      (started && $fell(clk_gated[i])) |-> $fell(clk_free[i])); // R8
  end
endmodule

bind clkgen_top clkgen_checker u_clkgen_checker (
  .core_clk   (core_clk),
  .rst_n      (rst_n),
  .clk_free   (clk_free),
  .clk_gated  (clk_gated),
  .rate_mon   (rate_mon),
  .cpu_switch (cpu_switch)
);

// File: tb/test_clkgen_top.sv
`timescale 1ns/1ps
module test_clkgen_top;
  localparam int HMID  = 33;
  localparam int HSLOW = 330;

  logic       clk_ref = 1'b0;
  logic       clk_ext = 1'b0;
  logic       use_ext = 1'b0;
  logic       rst_n   = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic [3:0] gate_en  = 4'hF;
  logic [3:0] clk_free;
  logic [3:0] clk_gated;
  logic [1:0] rate_mon;

  int  total = 0;
  int  bad   = 0;
  bit  cmp_on = 1'b0;
  bit  done   = 1'b0;

  always #2.5 clk_ref = ~clk_ref;

  clkgen_top #(.HALF_FAST(1), .HALF_MID(HMID), .HALF_SLOW(HSLOW)) i_clkgen_top (
    .clk_ref(clk_ref), .clk_ext(clk_ext), .use_ext(use_ext), .rst_n(rst_n),
    .rate_sel(rate_sel), .gate_en(gate_en), .clk_free(clk_free),
    .clk_gated(clk_gated), .rate_mon(rate_mon)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [3:0] m_lvl, m_enq, m_enl, m_gat, m_nf;
  int         m_cnt [4];
  int         m_act, m_req;

  function automatic int fixed_half(input int idx);
    if (idx == 0) return 1;
    if (idx == 2) return HMID;
    return HSLOW;
  endfunction

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      m_lvl = '0; m_enq = '1; m_enl = '1; m_gat = '0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
      m_act = 0; m_req = 0;
    end else if (!use_ext) begin
      for (int i = 0; i < 4; i++) begin
        if (i != 1) begin
          if (m_cnt[i] >= fixed_half(i) - 1) begin m_nf[i] = ~m_lvl[i]; m_cnt[i] = 0; end
          else begin m_nf[i] = m_lvl[i]; m_cnt[i]++; end
        end
      end
      if (m_cnt[1] >= (1 << m_act) - 1) begin
        m_cnt[1] = 0;
        if (!m_lvl[1] && m_req != m_act) begin m_act = m_req; m_nf[1] = 1'b0; end
        else m_nf[1] = ~m_lvl[1];
      end else begin
        m_nf[1] = m_lvl[1]; m_cnt[1]++;
      end
      for (int i = 0; i < 4; i++) begin
        if (!m_lvl[i]) begin
          m_gat[i] = m_nf[i] & m_enq[i];
          m_enl[i] = m_enq[i];
        end else begin
          m_gat[i] = m_nf[i] & m_enl[i];
        end
      end
      m_enq = gate_en;
      m_req = int'(rate_sel);
      m_lvl = m_nf;
    end
  end

  // per-cycle comparison and phase-length monitors
  int hi_cpu, lo_cpu, hi_gcpu;
  always @(negedge clk_ref) begin
    if (cmp_on && !use_ext) begin
      check(clk_free[0] == m_lvl[0], "R2 free0", clk_free[0], m_lvl[0]);
      check(clk_free[1] == m_lvl[1], "R3 free1", clk_free[1], m_lvl[1]);
      check(clk_free[2] == m_lvl[2], "R4 free2", clk_free[2], m_lvl[2]);
      check(clk_free[3] == m_lvl[3], "R4 free3", clk_free[3], m_lvl[3]);
      check(clk_gated == m_gat, "R7 gated", clk_gated, m_gat);
      check(int'(rate_mon) == m_act, "R6 rate_mon", rate_mon, m_act);
      if (clk_free[1]) begin
        if (lo_cpu >= 0)
          check(lo_cpu >= (1 << rate_mon), "R5 low phase length", lo_cpu, 1 << rate_mon);
        lo_cpu = -1;
        hi_cpu = (hi_cpu < 0) ? 1 : hi_cpu + 1;
      end else begin
        if (hi_cpu > 0)
          check(hi_cpu == (1 << rate_mon), "R5 high phase length", hi_cpu, 1 << rate_mon);
        hi_cpu = 0;
        lo_cpu = (lo_cpu < 0) ? 1 : lo_cpu + 1;
      end
      if (clk_gated[1]) hi_gcpu++;
      else begin
        if (hi_gcpu > 0)
          check(hi_gcpu == (1 << rate_mon), "R8 gated high length", hi_gcpu, 1 << rate_mon);
        hi_gcpu = 0;
      end
    end else begin
      hi_cpu = 0; lo_cpu = -2147483647; hi_gcpu = 0;
      lo_cpu = -1;
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic reset_check();
    @(negedge clk_ref);
    cmp_on = 1'b0;
    rst_n  = 1'b0;
    cycles(3);
    check(clk_free == 4'h0, "R1 free in reset", clk_free, 0);
    check(clk_gated == 4'h0, "R1 gated in reset", clk_gated, 0);
    check(rate_mon == 2'd0, "R1 rate_mon in reset", rate_mon, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] snap_f, snap_g;
    logic [1:0] snap_m;
    reset_check();
    cycles(6);
    check(rate_mon == 2'd0, "R9 divide-by-1 after reset", rate_mon, 0);
    check(clk_gated[1] == clk_free[1], "R9 gated enabled after reset", clk_gated[1], clk_free[1]);
    cycles(60);
    rate_sel = 2'd1; cycles(200);
    rate_sel = 2'd3; cycles(40);
    check(rate_mon == 2'd3, "R6 monitor shows code 3", rate_mon, 3);
    cycles(260);
    rate_sel = 2'd2; cycles(200);
    rate_sel = 2'd0; cycles(100);
    for (int k = 0; k < 12; k++) begin
      rate_sel = 2'(k % 4); cycles(1 + (k % 3));
    end
    rate_sel = 2'd3; cycles(120);
    gate_en = 4'b0101; cycles(800);
    check(clk_gated[1] == 1'b0 && clk_gated[3] == 1'b0, "R7 disabled gated low",
          int'(clk_gated), int'(clk_gated & 4'b0101));
    for (int k = 0; k < 40; k++) begin
      gate_en = 4'(k * 7 + 3); cycles(3 + (k % 5));
    end
    rate_sel = 2'd1;
    for (int k = 0; k < 40; k++) begin
      gate_en = 4'(k * 5 + 1); cycles(2 + (k % 4));
    end
    gate_en = 4'hF; cycles(700);

    // external clock path
    @(negedge clk_ref); #1;
    cmp_on = 1'b0;
    snap_f = clk_free; snap_g = clk_gated; snap_m = rate_mon;
    use_ext = 1'b1;
    cycles(20);
    check(clk_free == snap_f, "R10 free hold on idle ext", clk_free, snap_f);
    check(clk_gated == snap_g, "R10 gated hold on idle ext", clk_gated, snap_g);
    check(rate_mon == snap_m, "R10 monitor hold on idle ext", rate_mon, snap_m);
    for (int k = 0; k < 3; k++) begin
      #2 clk_ext = 1'b1;
      #2 clk_ext = 1'b0;
    end
    #1;
    check(clk_free[0] == ~snap_f[0], "R10 ext pulses drive fast output", clk_free[0], ~snap_f[0]);
    @(negedge clk_ref); #1;
    use_ext = 1'b0;

    reset_check();
    cycles(100);
    rate_sel = 2'd2; cycles(100);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule